// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

The walker steps through a table of region descriptors in memory and converts it into a stream of (address, length) transfer requests for a downstream data mover. A single `start_i` pulse loads the table base and the total number of bytes wanted. Each descriptor is eight bytes: a 32-bit buffer address word, then a 32-bit size word. Both words arrive through a 32-bit read port with a valid/ready request channel and a valid-only response channel. A descriptor is fetched only when the bytes left in the current region have run out.

The size word gives an even byte count. A count of zero means a full 64 KiB region, and the top bit marks the final entry. The walker hands out chunks. Each chunk is limited by the bytes still wanted, the bytes left in the region, and a parameterised per-request cap. When the mover stalls, the walker holds the current chunk. The region position it keeps lets a large region be issued as several chunks from a single fetch.

A walk ends with a one-cycle `done_o` when the requested total has been issued. It ends with a one-cycle `error_o` when the table runs out first. The table runs out either because the final entry has been consumed or because the table pointer has moved a full 4096-byte page past the base.

Top module: `sg_table_walker`

## Requirements
- R1: After reset, `mem_req_valid_o`, `xfer_valid_o`, `done_o` and `error_o` are all low.
- R2: A descriptor is read as two beats. The first beat reads the address word at the table pointer and the second reads the size word at pointer+4. The first descriptor sits at the table base and each later one sits 8 bytes above the previous.
- R3: The region length is bits 15:0 of the size word with bit 0 forced to zero. Bits 30:16 have no effect.
- R4: A masked length of zero gives a region of 65536 bytes.
- R5: Each chunk is the smallest of the bytes still requested, the bytes left in the region, and MAX_CHUNK (default 512). Successive chunks within a region have contiguous addresses starting at the descriptor's address word.
- R6: A new descriptor is fetched only after the current region is exhausted, so a region longer than MAX_CHUNK yields several chunks from one fetch.
- R7: Bit 31 of the size word marks the final entry. If requested bytes remain once that region is exhausted, `error_o` pulses for one cycle and no further read is issued.
- R8: No descriptor is fetched once the table pointer is 4096 or more bytes above the base. Reaching that limit with bytes still requested pulses `error_o`, so at most 512 descriptors are read per walk.
- R9: When the requested total has been issued, `done_o` pulses for exactly one cycle. This also happens when the total is reached partway through a region, and then no further descriptor is read. `done_o` and `error_o` are never high together.
- R10: A start with a requested total of zero gives `done_o` and issues no memory read and no chunk.
- R11: `start_i` has no effect while a walk is in progress. A start from idle discards any leftover region state and walks from the new base.
- R12: While `xfer_valid_o` is high and `xfer_ready_i` is low, the chunk address and length stay unchanged. While `mem_req_valid_o` is high and `mem_req_ready_i` is low, the read address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk; only sampled while idle |
| table_base_i | input | 32 | Byte address of the first descriptor |
| req_bytes_i | input | CNT_W | Total bytes to issue for this walk |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the 32-bit word to read |
| mem_rsp_valid_i | input | 1 | Read data valid (always accepted) |
| mem_rsp_data_i | input | 32 | Read data word |
| xfer_valid_o | output | 1 | Chunk request valid |
| xfer_ready_i | input | 1 | Data mover accepts the chunk |
| xfer_addr_o | output | 32 | Chunk start address |
| xfer_len_o | output | 17 | Chunk length in bytes |
| done_o | output | 1 | One-cycle pulse: requested total issued |
| error_o | output | 1 | One-cycle pulse: table exhausted early |

## Verification
The hardest condition to reach is the page fail-safe. It only fires after 512 descriptors, none flagged final, have been consumed with bytes still owed. The stimulus builds a 512-entry table of 2-byte regions and places a decoy valid entry just past the page. It then asks for more bytes than the table holds, so the walk must stop on the pointer limit alone. The bench checks that the decoy address is never read. The 64 KiB encoding is exercised through a zero-count region split into 128 capped chunks. A stray start pulse is injected during that walk to show it is ignored. Random ready on both handshakes holds chunks and reads stalled throughout.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned SGW_LEN_W = 17;
  localparam int unsigned SGW_DESC_BYTES = 8;

  typedef enum logic [1:0] {W_IDLE, W_CHECK, W_FETCH, W_ISSUE} walk_st_e;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_RSP} fetch_st_e;

  typedef struct packed {
    logic [31:0]          addr;
    logic [SGW_LEN_W-1:0] len;
    logic                 last;
  } desc_t;
endpackage

// File: rtl/sgw_desc_fetch.sv
module sgw_desc_fetch
  import sgw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic [31:0] ptr_i,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i,
  output logic        desc_valid_o,
  output desc_t       desc_o
);
  fetch_st_e   st_q;
  logic        beat_q;
  logic [31:0] ptr_q;
  logic [31:0] word0_q;
  logic        dv_q;
  desc_t       desc_q;
  desc_t       dec;
  logic [15:0] masked;

  always_comb begin
    masked   = mem_rsp_data_i[15:0] & 16'hFFFE;
    dec.addr = word0_q;
    dec.len  = (masked == 16'h0) ? SGW_LEN_W'(17'h10000) : SGW_LEN_W'(masked);
    dec.last = mem_rsp_data_i[31];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      beat_q  <= 1'b0;
      ptr_q   <= '0;
      word0_q <= '0;
      dv_q    <= 1'b0;
      desc_q  <= '0;
    end else begin
      dv_q <= 1'b0;
      case (st_q)
        F_IDLE: if (go_i) begin
          ptr_q  <= ptr_i;
          beat_q <= 1'b0;
          st_q   <= F_REQ;
        end
        F_REQ: if (mem_req_ready_i) st_q <= F_RSP;
        F_RSP: if (mem_rsp_valid_i) begin
          if (!beat_q) begin
            word0_q <= mem_rsp_data_i;
            beat_q  <= 1'b1;
            st_q    <= F_REQ;
          end else begin
            desc_q <= dec;
            dv_q   <= 1'b1;
            st_q   <= F_IDLE;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (st_q == F_REQ);
  assign mem_req_addr_o  = ptr_q + (beat_q ? 32'd4 : 32'd0);
  assign desc_valid_o    = dv_q;
  assign desc_o          = desc_q;

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_desc_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (desc_o.len[0] == 1'b0) && (desc_o.len != '0));
endmodule

// File: rtl/sgw_chunk_sel.sv
module sgw_chunk_sel #(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned LEN_W     = 17,
  parameter int unsigned MAX_CHUNK = 512
) (
  input  logic [CNT_W-1:0] left_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [LEN_W-1:0] chunk_o
);
  localparam int unsigned CMP_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [CMP_W-1:0] l_w, r_w, m_w;

  always_comb begin
    l_w = CMP_W'(left_i);
    r_w = CMP_W'(rem_i);
    m_w = (l_w < r_w) ? l_w : r_w;
  end

  generate
    if (MAX_CHUNK >= 65536) begin : g_uncapped
      assign chunk_o = LEN_W'(m_w);
    end else begin : g_capped
      localparam logic [CMP_W-1:0] CAP = CMP_W'(MAX_CHUNK);
      assign chunk_o = LEN_W'((m_w < CAP) ? m_w : CAP);
    end
  endgenerate
endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sgw_pkg::*;
#(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned MAX_CHUNK  = 512,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [31:0]          table_base_i,
  input  logic [CNT_W-1:0]     req_bytes_i,
  output logic                 mem_req_valid_o,
  input  logic                 mem_req_ready_i,
  output logic [31:0]          mem_req_addr_o,
  input  logic                 mem_rsp_valid_i,
  input  logic [31:0]          mem_rsp_data_i,
  output logic                 xfer_valid_o,
  input  logic                 xfer_ready_i,
  output logic [31:0]          xfer_addr_o,
  output logic [SGW_LEN_W-1:0] xfer_len_o,
  output logic                 done_o,
  output logic                 error_o
);
  walk_st_e             st_q;
  logic [31:0]          base_q, ptr_q, raddr_q;
  logic [SGW_LEN_W-1:0] rem_q;
  logic [CNT_W-1:0]     left_q;
  logic                 last_q, done_q, err_q;
  logic                 page_hit, fetch_go, desc_valid;
  desc_t                desc;
  logic [SGW_LEN_W-1:0] chunk;

  assign page_hit = (ptr_q - base_q) >= 32'(PAGE_BYTES);
  assign fetch_go = (st_q == W_CHECK) && (left_q != '0) && (rem_q == '0)
                    && !last_q && !page_hit;

  sgw_desc_fetch u_fetch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .go_i            (fetch_go),
    .ptr_i           (ptr_q),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .desc_valid_o    (desc_valid),
    .desc_o          (desc)
  );

  sgw_chunk_sel #(
    .CNT_W     (CNT_W),
    .LEN_W     (SGW_LEN_W),
    .MAX_CHUNK (MAX_CHUNK)
  ) u_chunk (
    .left_i  (left_q),
    .rem_i   (rem_q),
    .chunk_o (chunk)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= W_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
      raddr_q <= '0;
      rem_q   <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        W_IDLE: if (start_i) begin
          base_q  <= table_base_i;
          ptr_q   <= table_base_i;
          left_q  <= req_bytes_i;
          rem_q   <= '0;
          raddr_q <= '0;
          last_q  <= 1'b0;
          st_q    <= W_CHECK;
        end
        W_CHECK: begin
          if (left_q == '0) begin
            done_q <= 1'b1;
            st_q   <= W_IDLE;
          end else if (rem_q != '0) begin
            st_q <= W_ISSUE;
          end else if (last_q || page_hit) begin
            err_q <= 1'b1;
            st_q  <= W_IDLE;
          end else begin
            st_q <= W_FETCH;
          end
        end
        W_FETCH: if (desc_valid) begin
          raddr_q <= desc.addr;
          rem_q   <= desc.len;
          last_q  <= desc.last;
          ptr_q   <= ptr_q + 32'(SGW_DESC_BYTES);
          st_q    <= W_CHECK;
        end
        W_ISSUE: if (xfer_ready_i) begin
          raddr_q <= raddr_q + 32'(chunk);
          rem_q   <= rem_q - chunk;
          left_q  <= left_q - CNT_W'(chunk);
          st_q    <= W_CHECK;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign xfer_valid_o = (st_q == W_ISSUE);
  assign xfer_addr_o  = raddr_q;
  assign xfer_len_o   = chunk;
  assign done_o       = done_q;
  assign error_o      = err_q;

  assert_xfer_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o));

  assert_chunk_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> (xfer_len_o != '0) && (32'(xfer_len_o) <= 32'(MAX_CHUNK)));

  assert_pulse_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_no_read_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !last_q && !xfer_valid_o);

  assert_page_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_valid_o) |-> (mem_req_addr_o - base_q) < 32'(PAGE_BYTES));
endmodule

// File: tb/tb_sg_table_walker.sv
module tb_sg_table_walker;
  localparam int CNT_W = 24;
  localparam int MAXC  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] table_base_i = '0;
  logic [CNT_W-1:0] req_bytes_i = '0;
  logic        mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        xfer_valid_o, xfer_ready_i = 1'b0;
  logic [31:0] xfer_addr_o;
  logic [16:0] xfer_len_o;
  logic        done_o, error_o;

  always #4 clk = ~clk;

  sg_table_walker #(.CNT_W(CNT_W), .MAX_CHUNK(MAXC), .PAGE_BYTES(4096)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .table_base_i(table_base_i),
    .req_bytes_i(req_bytes_i), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_addr_o(xfer_addr_o), .xfer_len_o(xfer_len_o),
    .done_o(done_o), .error_o(error_o));

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [31:0] mem [int unsigned];
  logic [31:0] exp_xa[$];
  int          exp_xl[$];
  logic [31:0] exp_fa[$];
  bit          exp_err;
  int          exp_nf;
  int          got_nf;
  string       cur_req = "R1";

  function automatic logic [31:0] rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic put_desc(logic [31:0] at, logic [31:0] a, logic [31:0] s);
    mem[at] = a;
    mem[at + 4] = s;
  endtask

  task automatic check(bit ok, string r, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  // Behavioural walk: fills expected fetch list, chunk list and outcome.
  task automatic model(logic [31:0] base, longint req);
    longint left, rem, c, len;
    logic [31:0] ptr, ra, s;
    bit last;
    exp_xa.delete(); exp_xl.delete(); exp_fa.delete();
    ptr = base; left = req; rem = 0; last = 0; ra = 0; exp_err = 0;
    forever begin
      if (left == 0) break;
      if (rem == 0) begin
        if (last || (ptr - base) >= 4096) begin exp_err = 1; break; end
        exp_fa.push_back(ptr); exp_fa.push_back(ptr + 4);
        ra = rd(ptr); s = rd(ptr + 4);
        len = longint'(s[15:0] & 16'hFFFE);
        if (len == 0) len = 65536;
        rem = len; last = s[31]; ptr = ptr + 8;
      end
      c = left; if (rem < c) c = rem; if (MAXC < c) c = MAXC;
      exp_xa.push_back(ra); exp_xl.push_back(int'(c));
      ra = ra + 32'(c); rem -= c; left -= c;
    end
    exp_nf = exp_fa.size() / 2;
  endtask

  // Negedge driver/monitor: random ready, memory responder, per-clock comparison.
  bit          pend = 0;
  int          dly = 0;
  logic [31:0] pend_a = '0;
  bit          prev_wait = 0;
  logic [31:0] prev_xa = '0;
  logic [16:0] prev_xl = '0;
  bit          prev_done = 0, prev_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      mem_rsp_valid_i = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = rd(pend_a);
          pend = 0;
        end else dly--;
      end
      mem_req_ready_i = ($urandom % 4) != 0;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (exp_fa.size() == 0) check(0, "R2 unexpected read", mem_req_addr_o, 0);
        else begin
          check(mem_req_addr_o == exp_fa[0], "R2 read address", mem_req_addr_o, exp_fa[0]);
          void'(exp_fa.pop_front());
        end
        if (mem_req_addr_o[2] == 1'b0) got_nf++;
        pend = 1; pend_a = mem_req_addr_o; dly = $urandom % 3;
      end
      if (prev_wait)
        check(xfer_valid_o && xfer_addr_o == prev_xa && xfer_len_o == prev_xl,
              "R12 chunk held", {xfer_addr_o, xfer_len_o}, {prev_xa, prev_xl});
      xfer_ready_i = ($urandom % 4) != 0;
      if (xfer_valid_o && xfer_ready_i) begin
        if (exp_xa.size() == 0) check(0, {cur_req, " unexpected chunk"}, xfer_addr_o, 0);
        else begin
          check(xfer_addr_o == exp_xa[0], {cur_req, " chunk address"}, xfer_addr_o, exp_xa[0]);
          check(int'(xfer_len_o) == exp_xl[0], {cur_req, " chunk length"}, xfer_len_o, exp_xl[0]);
          void'(exp_xa.pop_front()); void'(exp_xl.pop_front());
        end
      end
      prev_wait = xfer_valid_o && !xfer_ready_i;
      prev_xa = xfer_addr_o; prev_xl = xfer_len_o;
      if (prev_done) check(!done_o, "R9 done one cycle", done_o, 0);
      if (prev_err)  check(!error_o, "R7 error one cycle", error_o, 0);
      prev_done = done_o; prev_err = error_o;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_walk(logic [31:0] base, longint req, string r, bit poke);
    bit fin = 0, got_err = 0;
    int n = 0;
    cur_req = r;
    model(base, req);
    got_nf = 0;
    @(negedge clk);
    start_i = 1'b1; table_base_i = base; req_bytes_i = CNT_W'(req);
    @(negedge clk);
    start_i = 1'b0;
    while (!fin && n < 30000) begin
      @(negedge clk);
      n++;
      if (poke && n == 20) begin
        start_i = 1'b1; table_base_i = 32'h0000_1000; req_bytes_i = 24'd4;
      end else if (poke && n == 21) start_i = 1'b0;
      if (done_o || error_o) begin fin = 1; got_err = error_o; end
    end
    if (!fin) check(0, {r, " watchdog"}, n, 30000);
    check(got_err == exp_err, {r, " outcome error flag"}, got_err, exp_err);
    check(exp_xa.size() == 0, {r, " chunks outstanding"}, exp_xa.size(), 0);
    check(got_nf == exp_nf, {r, " descriptor fetch count"}, got_nf, exp_nf);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R2/R3/R5: three entries, junk high bits and odd counts
    put_desc(32'h1000, 32'h2000_0000, 32'h0000_0101);
    put_desc(32'h1008, 32'h3000_0004, 32'h7FFF_0081);
    put_desc(32'h1010, 32'h4000_0000, 32'h8000_0040);
    // R4/R6: single zero-count final entry
    put_desc(32'h2000, 32'h5000_0000, 32'h8000_0000);
    // R9: big first region
    put_desc(32'h3000, 32'h6000_0000, 32'h0000_1000);
    put_desc(32'h3008, 32'h6100_0000, 32'h8000_0010);
    // R8: 512 non-final 2-byte entries plus a decoy past the page
    for (int i = 0; i < 512; i++)
      put_desc(32'h1_0000 + 32'(i * 8), 32'h7000_0000 + 32'(i * 16), 32'h0000_0002);
    put_desc(32'h1_1000, 32'h7F00_0000, 32'h8000_0100);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req_valid_o && !xfer_valid_o && !done_o && !error_o, "R1 reset outputs",
          {mem_req_valid_o, xfer_valid_o, done_o, error_o}, 0);

    run_walk(32'h1000, 'h1C0, "R3 R5 exact table", 0);
    run_walk(32'h2000, 'h10000, "R4 R6 R11 full region", 1);
    run_walk(32'h1000, 'h1C1, "R7 table short", 0);
    run_walk(32'h3000, 'h300, "R9 mid-region end", 0);
    run_walk(32'h1000, 'h40, "R11 restart new base", 0);
    run_walk(32'h1000, 0, "R10 zero request", 0);
    run_walk(32'h1_0000, 5000, "R8 page limit", 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule